// File: doc/BRIEF.md
# Transmit FIFO Empty Interrupt Generator

This block watches the fill level of two transmit FIFOs, one for periodic traffic and one for non-periodic traffic, and raises a sticky "room available" status bit for each one. Each FIFO has its own threshold-select input. With the select at 0, status is raised once at least half of the FIFO is free. With the select at 1, status is raised only when the FIFO holds nothing at all.

A single interrupt line goes to the application. It is the registered OR of the two status bits, gated by a global unmask input. The unmask input acts on the line only: the status bits keep following the FIFO levels whatever its value.

Software acknowledges an event with a clear strobe. The strobe drops a status bit only if that FIFO's threshold condition no longer holds. All configuration inputs are expected to sit at 0 after reset, so by default the half-empty threshold applies and the line is masked.

Top module: `txfifo_empty_irq`

## Requirements
- R1: While reset is high and after reset is released, both status bits and the interrupt line are 0 until a threshold condition is seen.
- R2: With select 0, a FIFO's status bit reads 1 on the clock edge after its free space (depth minus level), doubled, is greater than or equal to its depth. It stays 0 while the doubled free space is less than the depth.
- R3: With select 1, a FIFO's status bit is set only after a cycle in which that FIFO's level is exactly 0. A level of 1 does not set it.
- R4: The periodic select input applies only to the periodic FIFO, and the non-periodic select input applies only to the non-periodic FIFO.
- R5: A status bit that is set stays set when the level rises above the threshold again, as long as no clear strobe arrives.
- R6: A clear strobe drops a status bit on the next edge only when that FIFO's threshold condition is false in the strobe cycle. If the condition is true, the bit stays 1.
- R7: The interrupt line reads 1 one edge after a status bit becomes 1 while unmask is 1. It returns to 0 one edge after both status bits are 0.
- R8: With unmask at 0, the interrupt line is 0 on the next edge, and the status bits still set and hold as in R2 to R6.
- R9: For an odd depth, the half-empty threshold is exact. With depth 7, a free space of 3 does not set status, and a free space of 4 does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| per_level | input | CNT_W | Words held in the periodic FIFO |
| per_depth | input | CNT_W | Capacity of the periodic FIFO |
| nper_level | input | CNT_W | Words held in the non-periodic FIFO |
| nper_depth | input | CNT_W | Capacity of the non-periodic FIFO |
| per_thr_sel | input | 1 | Periodic threshold: 0 half free, 1 fully empty |
| nper_thr_sel | input | 1 | Non-periodic threshold: 0 half free, 1 fully empty |
| irq_unmask | input | 1 | 1 lets status reach the interrupt line |
| sts_clr | input | 1 | One-cycle status clear strobe |
| per_empty_sts | output | 1 | Sticky periodic room-available status |
| nper_empty_sts | output | 1 | Sticky non-periodic room-available status |
| irq | output | 1 | Interrupt line to the application |

## Verification
The level sweeps step each FIFO just below and just onto its threshold, using an even depth of 16 and an odd depth of 7. These steps separate a greater-or-equal comparison from a strict one, and a rounded half from an exact one. The two FIFOs are given opposite select values at the same time, which exposes any swap or sharing of the select inputs. Clear strobes are sent with the condition both true and false, to tell a sticky bit with a guarded clear from an unconditional one. Toggling unmask while status is held shows that the mask reaches only the line, and that the line lags status by one registered stage.

// File: rtl/txe_pkg.sv
package txe_pkg;

    typedef enum logic {
        THR_HALF_FREE = 1'b0,
        THR_ALL_FREE  = 1'b1
    } thr_mode_t;

    localparam int NUM_FIFO = 2;
    localparam int IDX_PER  = 0;
    localparam int IDX_NPER = 1;

    typedef struct packed {
        logic nper;
        logic per;
    } sts_pair_t;

endpackage

// File: rtl/txe_thresh_detect.sv
module txe_thresh_detect
    import txe_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] level,
    input  logic [CNT_W-1:0] depth,
    input  thr_mode_t        mode,
    output logic             hit
);
    localparam int EXT_W = CNT_W + 2;

    logic [EXT_W-1:0] free_x2;
    logic [EXT_W-1:0] depth_x;

    always_comb begin
        depth_x = EXT_W'(depth);
        free_x2 = EXT_W'(depth - level) << 1;
        unique case (mode)
            THR_HALF_FREE: hit = (free_x2 >= depth_x);
            THR_ALL_FREE:  hit = (level == '0);
            default:       hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/txe_sticky_flag.sv
module txe_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= set | (q & ~clr);
    end

    assert_set_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(q) |-> $past(set));

    assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(q) |-> $past(clr));

    assert_clear_guard_R6: assert property (@(posedge clk) disable iff (rst)
        $past(set) |-> q);
endmodule

// File: rtl/txe_irq_line.sv
module txe_irq_line
    import txe_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sts_pair_t sts,
    input  logic      unmask,
    output logic      irq
);
    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= unmask & (sts.per | sts.nper);
    end

    assert_mask_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(unmask) |-> !irq);

    assert_irq_source_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(sts.per || sts.nper));
endmodule

// File: rtl/txfifo_empty_irq.sv
module txfifo_empty_irq
    import txe_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] per_level,
    input  logic [CNT_W-1:0] per_depth,
    input  logic [CNT_W-1:0] nper_level,
    input  logic [CNT_W-1:0] nper_depth,
    input  logic             per_thr_sel,
    input  logic             nper_thr_sel,
    input  logic             irq_unmask,
    input  logic             sts_clr,
    output logic             per_empty_sts,
    output logic             nper_empty_sts,
    output logic             irq
);
    logic [CNT_W-1:0] lvl_a [NUM_FIFO];
    logic [CNT_W-1:0] dep_a [NUM_FIFO];
    thr_mode_t        mode_a[NUM_FIFO];
    logic             hit_a [NUM_FIFO];
    logic             sts_a [NUM_FIFO];
    sts_pair_t        sts_bus;

    always_comb begin
        lvl_a[IDX_PER]   = per_level;
        lvl_a[IDX_NPER]  = nper_level;
        dep_a[IDX_PER]   = per_depth;
        dep_a[IDX_NPER]  = nper_depth;
        mode_a[IDX_PER]  = thr_mode_t'(per_thr_sel);
        mode_a[IDX_NPER] = thr_mode_t'(nper_thr_sel);
    end

    for (genvar g = 0; g < NUM_FIFO; g++) begin : g_fifo
        txe_thresh_detect #(.CNT_W(CNT_W)) u_det (
            .level (lvl_a[g]),
            .depth (dep_a[g]),
            .mode  (mode_a[g]),
            .hit   (hit_a[g])
        );

        txe_sticky_flag u_flag (
            .clk (clk),
            .rst (rst),
            .set (hit_a[g]),
            .clr (sts_clr),
            .q   (sts_a[g])
        );

        assert_empty_mode_R3: assert property (@(posedge clk) disable iff (rst)
            ($rose(sts_a[g]) && $past(mode_a[g] == THR_ALL_FREE)) |-> ($past(lvl_a[g]) == '0));
    end

    always_comb begin
        sts_bus.per  = sts_a[IDX_PER];
        sts_bus.nper = sts_a[IDX_NPER];
    end

    txe_irq_line u_line (
        .clk    (clk),
        .rst    (rst),
        .sts    (sts_bus),
        .unmask (irq_unmask),
        .irq    (irq)
    );

    assign per_empty_sts  = sts_a[IDX_PER];
    assign nper_empty_sts = sts_a[IDX_NPER];

    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (!per_empty_sts && !nper_empty_sts && !irq));
endmodule

// File: tb/txfifo_empty_irq_test.sv
module txfifo_empty_irq_test;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [CNT_W-1:0] per_level = 8'd16, per_depth = 8'd16;
    logic [CNT_W-1:0] nper_level = 8'd7, nper_depth = 8'd7;
    logic per_thr_sel = 1'b0, nper_thr_sel = 1'b0;
    logic irq_unmask = 1'b0, sts_clr = 1'b0;
    logic per_empty_sts, nper_empty_sts, irq;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txfifo_empty_irq #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst),
        .per_level(per_level), .per_depth(per_depth),
        .nper_level(nper_level), .nper_depth(nper_depth),
        .per_thr_sel(per_thr_sel), .nper_thr_sel(nper_thr_sel),
        .irq_unmask(irq_unmask), .sts_clr(sts_clr),
        .per_empty_sts(per_empty_sts), .nper_empty_sts(nper_empty_sts),
        .irq(irq)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic got, input logic exp, input string what);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %0b expected %0b", what, got, exp);
        end
    endtask

    task automatic fill_both();
        per_level  = per_depth;
        nper_level = nper_depth;
    endtask

    task automatic pulse_clr();
        sts_clr = 1'b1;
        step(1);
        sts_clr = 1'b0;
    endtask

    task automatic t_reset();
        step(3);
        check(per_empty_sts, 1'b0, "R1 per status in reset");
        check(irq, 1'b0, "R1 irq in reset");
        rst = 1'b0;
        step(2);
        check(per_empty_sts, 1'b0, "R1 per status after reset");
        check(nper_empty_sts, 1'b0, "R1 nper status after reset");
        check(irq, 1'b0, "R1 irq after reset");
    endtask

    task automatic t_half();
        per_level = 8'd9;  nper_level = 8'd4;
        step(1);
        check(per_empty_sts, 1'b0, "R2 free 7 of 16");
        check(nper_empty_sts, 1'b0, "R9 free 3 of 7");
        per_level = 8'd8;  nper_level = 8'd3;
        step(1);
        check(per_empty_sts, 1'b1, "R2 free 8 of 16");
        check(nper_empty_sts, 1'b1, "R9 free 4 of 7");
        step(1);
        check(irq, 1'b0, "R8 masked line");
        fill_both();
        pulse_clr();
        check(per_empty_sts, 1'b0, "R6 per clear when false");
        check(nper_empty_sts, 1'b0, "R6 nper clear when false");
    endtask

    task automatic t_full();
        per_thr_sel = 1'b1; nper_thr_sel = 1'b0;
        per_level = 8'd1;   nper_level = 8'd3;
        step(1);
        check(per_empty_sts, 1'b0, "R3 level 1 no set");
        check(nper_empty_sts, 1'b1, "R4 nper keeps half mode");
        per_level = 8'd0;
        step(1);
        check(per_empty_sts, 1'b1, "R3 level 0 sets");
        fill_both();
        step(2);
        check(per_empty_sts, 1'b1, "R5 per sticky");
        check(nper_empty_sts, 1'b1, "R5 nper sticky");
        pulse_clr();
        check(per_empty_sts, 1'b0, "R6 clear after sticky");
        per_thr_sel = 1'b0; nper_thr_sel = 1'b1;
        per_level = 8'd8;   nper_level = 8'd1;
        step(1);
        check(per_empty_sts, 1'b1, "R4 per half mode");
        check(nper_empty_sts, 1'b0, "R4 nper full mode level 1");
        fill_both();
        pulse_clr();
        nper_thr_sel = 1'b0;
    endtask

    task automatic t_clr_hold();
        per_level = 8'd0;
        step(1);
        sts_clr = 1'b1;
        step(1);
        sts_clr = 1'b0;
        check(per_empty_sts, 1'b1, "R6 clear ignored while condition true");
        fill_both();
        pulse_clr();
        check(per_empty_sts, 1'b0, "R6 clear after condition gone");
    endtask

    task automatic t_irq();
        irq_unmask = 1'b1;
        per_level = 8'd8;
        step(1);
        check(per_empty_sts, 1'b1, "R7 status set");
        check(irq, 1'b0, "R7 line lags status");
        step(1);
        check(irq, 1'b1, "R7 line raised");
        irq_unmask = 1'b0;
        step(1);
        check(irq, 1'b0, "R8 mask drops line");
        check(per_empty_sts, 1'b1, "R8 status kept while masked");
        irq_unmask = 1'b1;
        step(1);
        check(irq, 1'b1, "R7 unmask restores line");
        fill_both();
        pulse_clr();
        check(per_empty_sts, 1'b0, "R7 status cleared");
        check(irq, 1'b1, "R7 line one cycle behind clear");
        step(1);
        check(irq, 1'b0, "R7 line falls");
        irq_unmask = 1'b0;
        nper_level = 8'd0;
        step(1);
        check(nper_empty_sts, 1'b1, "R8 status sets while masked");
        step(1);
        check(irq, 1'b0, "R8 line stays low while masked");
    endtask

    initial begin
        t_reset();
        t_half();
        t_full();
        t_clr_hold();
        t_irq();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule